// File: doc/BRIEF.md
# External Bus Wait-State Controller

This block carries single transfers from an on-chip master to an external memory with a 16-bit data path. The master offers a request with a size of byte, half-word or word, an address, write data and a direction. The block takes the request only while `req_ready` is high. It then drives the external chip select, a read strobe or a write strobe, the address, the write data and a byte-lane select.

A word transfer is split into two 16-bit bus cycles: the lower half first, then the upper half at the address plus two. One idle clock separates the two cycles, and the chip select stays low during that clock. Every bus cycle lasts a configured number of standard wait states plus one clock. The active-low `ext_wait_n` input can stretch any cycle further, and this includes each half of a word.

The wait input passes through a synchroniser. For that reason the controller looks at it only once the standard wait-state count has run out. Read data is captured at the edge that ends each cycle and is assembled into a 32-bit result. The result is returned with a one-clock `done` pulse. The wait-state configuration `cfg_ws` must stay constant while a transfer is in progress.

Top module: `xbus_wait_ctrl`

## Requirements
- R1: While `rst` is high and in the first clock after it, `bus_cs_n`, `bus_rd_n` and `bus_we_n` are high, `done` is low and `req_ready` is high.
- R2: A request is taken at a rising edge only if `req_valid` and `req_ready` are both high. From that edge until the `done` clock, `req_ready` is low. Any change of `req_valid`, `req_addr` or `req_wdata` during that time has no effect on the bus address, the bus data or the number of cycles in the transfer.
- R3: `req_size` is encoded as 0 = byte, 1 = half-word, 2 or 3 = word. The effective wait count `nws_eff` equals `cfg_ws`, raised to 2 for words and for every write, and raised to 1 for byte and half-word reads. With `ext_wait_n` held high, each strobe stays low for exactly `nws_eff`+1 clocks.
- R4: A cycle ends at the first rising edge that meets two conditions. First, it comes at least `nws_eff`+1 clocks after the strobe went low. Second, `ext_wait_n` was high when sampled two rising edges before it. As a result, each low sample that is seen in time lengthens the strobe by one clock.
- R5: A word transfer makes two strobe cycles. The first is at `req_addr` and the second at `req_addr`+2. Between them lies exactly one clock with `bus_cs_n` low and both strobes high. The second cycle keeps its own wait-state count and its own wait extension.
- R6: Read data `rdata` depends on the size. For a word it is {upper cycle data, lower cycle data}. For a half-word it is the 16 bits zero-extended. For a byte it is `bus_din[7:0]` when address bit 0 is 0 and `bus_din[15:8]` when it is 1, zero-extended. Each value is the one on `bus_din` at the edge that ends the cycle.
- R7: `bus_dout` carries the write data as follows. A word puts `req_wdata[15:0]` in the first cycle and `req_wdata[31:16]` in the second. A half-word puts `req_wdata[15:0]`. A byte puts `req_wdata[7:0]` on both lanes. `bus_bsel` is 2'b01 for a byte at an even address, 2'b10 for a byte at an odd address, and 2'b11 otherwise.
- R8: During a write only `bus_we_n` goes low, and during a read only `bus_rd_n` goes low. The active strobe stays low through every clock of the cycle, wait extensions included. It rises at the edge that ends the cycle. `bus_cs_n` is low whenever a strobe is low.
- R9: `done` is high for exactly one clock, the clock after the edge that ends the last cycle. In that clock `req_ready` is high and `rdata` holds the assembled read result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | High when idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Transfer size: 0 byte, 1 half-word, 2/3 word |
| req_addr | input | ADDR_W | Byte address of the transfer |
| req_wdata | input | 32 | Write data, right-aligned |
| cfg_ws | input | WS_W | Standard wait states per bus cycle |
| ext_wait_n | input | 1 | Active-low external wait, asynchronous |
| bus_cs_n | output | 1 | Active-low chip select |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_we_n | output | 1 | Active-low write enable |
| bus_addr | output | ADDR_W | External byte address |
| bus_dout | output | 16 | External write data |
| bus_bsel | output | 2 | Valid byte lanes (bit 0 low lane, bit 1 high lane) |
| bus_din | input | 16 | External read data |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 32 | Assembled read data, valid with `done` |

## Verification
The accept edge is the edge where `req_valid` meets a high `req_ready`. The strobe falls in the clock right after that edge and stays low for the number of clocks set by R3 and R4. For a word, that clock count is followed by one gap clock and then the count for the second cycle. `done` and `rdata` appear in the clock after the edge that ends the last cycle, and `done` drops one clock later.

The bench observes every signal 1 ns after each rising edge. It drives `ext_wait_n` in step with the count of strobe-low clocks seen so far. It counts strobe-low clocks per half and compares each total with a length derived from the R4 rule, which includes the two-edge synchroniser delay. It checks `rdata` only in the `done` clock.

// File: rtl/xbus_pkg.sv
`timescale 1ns/1ps
package xbus_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_WORDX = 2'd3
    } xsize_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_STRB = 2'd1,
        ST_GAP  = 2'd2
    } xstate_e;

    typedef struct packed {
        logic   wr;
        xsize_e sz;
    } xctl_t;

    function automatic logic is_word(xsize_e s);
        return (s == SZ_WORD) || (s == SZ_WORDX);
    endfunction

    // floor on the standard wait count for a given access type
    function automatic logic [1:0] min_ws(logic wr, xsize_e s);
        return (wr || is_word(s)) ? 2'd2 : 2'd1;
    endfunction

    function automatic logic [15:0] lane_out(xsize_e s, logic upper, logic [31:0] wd);
        logic [15:0] r;
        if (is_word(s))          r = upper ? wd[31:16] : wd[15:0];
        else if (s == SZ_HALF)   r = wd[15:0];
        else                     r = {wd[7:0], wd[7:0]};
        return r;
    endfunction

    function automatic logic [1:0] lane_sel(xsize_e s, logic a0);
        logic [1:0] r;
        if (s == SZ_BYTE) r = a0 ? 2'b10 : 2'b01;
        else              r = 2'b11;
        return r;
    endfunction

    function automatic logic [31:0] assemble(xsize_e s, logic a0,
                                             logic [15:0] lo, logic [15:0] din);
        logic [31:0] r;
        if (is_word(s))        r = {din, lo};
        else if (s == SZ_HALF) r = {16'h0000, din};
        else                   r = {24'h000000, (a0 ? din[15:8] : din[7:0])};
        return r;
    endfunction

endpackage

// File: rtl/xbus_wsync.sv
`timescale 1ns/1ps
module xbus_wsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] stage_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[g] <= 1'b1;
                    else     stage_q[g] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[g] <= 1'b1;
                    else     stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/xbus_seq.sv
`timescale 1ns/1ps
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int WS_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            accept,
    input  xctl_t           req_ctl,
    input  logic [WS_W-1:0] cfg_ws,
    input  logic            wait_s,
    output xctl_t           ctl,
    output logic            idle,
    output logic            strb,
    output logic            upper,
    output logic            capture,
    output logic            last,
    output logic            done
);
    xstate_e         st_q;
    xctl_t           ctl_q;
    logic [WS_W-1:0] cnt_q;
    logic [WS_W-1:0] lim;
    logic [WS_W-1:0] floor_ws;
    logic            half_q;
    logic            done_q;
    logic            at_final;

    always_comb begin
        floor_ws = WS_W'(min_ws(ctl_q.wr, ctl_q.sz));
        lim      = (cfg_ws < floor_ws) ? floor_ws : cfg_ws;
        at_final = (cnt_q == lim);
        capture  = (st_q == ST_STRB) && at_final && wait_s;
        last     = capture && (!is_word(ctl_q.sz) || half_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            ctl_q  <= '0;
            cnt_q  <= '0;
            half_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (accept) begin
                        ctl_q  <= req_ctl;
                        st_q   <= ST_STRB;
                        cnt_q  <= '0;
                        half_q <= 1'b0;
                    end
                end
                ST_STRB: begin
                    if (!at_final) begin
                        cnt_q <= cnt_q + 1'b1;
                    end else if (capture) begin
                        if (last) begin
                            st_q   <= ST_IDLE;
                            done_q <= 1'b1;
                        end else begin
                            st_q   <= ST_GAP;
                            half_q <= 1'b1;
                        end
                    end
                end
                ST_GAP: begin
                    st_q  <= ST_STRB;
                    cnt_q <= '0;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign ctl   = ctl_q;
    assign idle  = (st_q == ST_IDLE);
    assign strb  = (st_q == ST_STRB);
    assign upper = half_q;
    assign done  = done_q;

    // a strobe never lasts a single clock: the floor is one wait state
    assert_min_len_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(strb) |=> strb);

    // a low synchronised wait at the final count holds the strobe
    assert_wait_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (strb && at_final && !wait_s) |=> strb);

    assert_done_after_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(strb));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: rtl/xbus_dpath.sv
`timescale 1ns/1ps
module xbus_dpath
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    input  xctl_t             ctl,
    input  logic              strb,
    input  logic              upper,
    input  logic              capture,
    input  logic              last,
    input  logic [15:0]       bus_din,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [15:0]       bus_dout,
    output logic [1:0]        bus_bsel,
    output logic [31:0]       rdata
);
    localparam logic [ADDR_W-1:0] HALF_STEP = ADDR_W'(2);

    logic [ADDR_W-1:0] addr_q;
    logic [31:0]       wd_q;
    logic [15:0]       lo_q;
    logic [31:0]       rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            wd_q   <= '0;
            lo_q   <= '0;
            rd_q   <= '0;
        end else begin
            if (accept) begin
                addr_q <= req_addr;
                wd_q   <= req_wdata;
            end
            if (capture && !last)
                lo_q <= bus_din;
            if (last && !ctl.wr)
                rd_q <= assemble(ctl.sz, addr_q[0], lo_q, bus_din);
        end
    end

    always_comb begin
        bus_addr = upper ? (addr_q + HALF_STEP) : addr_q;
        bus_dout = lane_out(ctl.sz, upper, wd_q);
        bus_bsel = lane_sel(ctl.sz, addr_q[0]);
    end

    assign rdata = rd_q;

    // address held steady across a strobe regardless of new request inputs
    assert_addr_stable_R2: assert property (@(posedge clk) disable iff (rst)
        (strb && $past(strb)) |-> $stable(bus_addr));
endmodule

// File: rtl/xbus_wait_ctrl.sv
`timescale 1ns/1ps
module xbus_wait_ctrl
    import xbus_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int WS_W        = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    input  logic [WS_W-1:0]   cfg_ws,
    input  logic              ext_wait_n,
    output logic              bus_cs_n,
    output logic              bus_rd_n,
    output logic              bus_we_n,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [15:0]       bus_dout,
    output logic [1:0]        bus_bsel,
    input  logic [15:0]       bus_din,
    output logic              done,
    output logic [31:0]       rdata
);
    xctl_t req_ctl;
    xctl_t ctl;
    logic  wait_s;
    logic  idle, strb, upper, capture, last;
    logic  accept;

    assign req_ctl = '{wr: req_write, sz: xsize_e'(req_size)};
    assign accept  = req_valid && idle;

    xbus_wsync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (ext_wait_n),
        .dout (wait_s)
    );

    xbus_seq #(.WS_W(WS_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .req_ctl (req_ctl),
        .cfg_ws  (cfg_ws),
        .wait_s  (wait_s),
        .ctl     (ctl),
        .idle    (idle),
        .strb    (strb),
        .upper   (upper),
        .capture (capture),
        .last    (last),
        .done    (done)
    );

    xbus_dpath #(.ADDR_W(ADDR_W)) u_dpath (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .ctl       (ctl),
        .strb      (strb),
        .upper     (upper),
        .capture   (capture),
        .last      (last),
        .bus_din   (bus_din),
        .bus_addr  (bus_addr),
        .bus_dout  (bus_dout),
        .bus_bsel  (bus_bsel),
        .rdata     (rdata)
    );

    assign req_ready = idle;
    assign bus_cs_n  = idle;
    assign bus_rd_n  = !(strb && !ctl.wr);
    assign bus_we_n  = !(strb && ctl.wr);

    assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (rst)
        !(!bus_rd_n && !bus_we_n));

    assert_cs_cover_R8: assert property (@(posedge clk) disable iff (rst)
        (!bus_rd_n || !bus_we_n) |-> !bus_cs_n);

    assert_busy_R2: assert property (@(posedge clk) disable iff (rst)
        !bus_cs_n |-> !req_ready);
endmodule

// File: tb/sim_xbus_wait_ctrl.sv
`timescale 1ns/1ps
module sim_xbus_wait_ctrl;
    localparam int AW = 24;
    localparam int WW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [1:0]    req_size = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic [WW-1:0] cfg_ws = '0;
    logic          ext_wait_n = 1'b1;
    logic          bus_cs_n, bus_rd_n, bus_we_n;
    logic [AW-1:0] bus_addr;
    logic [15:0]   bus_dout;
    logic [1:0]    bus_bsel;
    logic [15:0]   bus_din = '0;
    logic          done;
    logic [31:0]   rdata;

    always #2.5 clk = ~clk;

    xbus_wait_ctrl #(.ADDR_W(AW), .WS_W(WW)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
        .req_wdata(req_wdata), .cfg_ws(cfg_ws), .ext_wait_n(ext_wait_n),
        .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_we_n(bus_we_n),
        .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_bsel(bus_bsel),
        .bus_din(bus_din), .done(done), .rdata(rdata)
    );

    typedef struct packed {
        logic        wr;
        logic [1:0]  sz;
        logic [23:0] ad;
        logic [31:0] wd;
        logic [3:0]  ws;
        logic [3:0]  l0;
        logic [3:0]  l1;
        logic [15:0] dlo;
        logic [15:0] dhi;
    } vec_t;

    // l0/l1: clocks of each strobe during which ext_wait_n is driven low, from its first clock
    localparam int NV = 11;
    localparam vec_t VEC [0:NV-1] = '{
        '{1'b0, 2'd2, 24'h000100, 32'h0,         4'd2, 4'd0, 4'd0, 16'h1234, 16'hABCD},
        '{1'b0, 2'd2, 24'h000104, 32'h0,         4'd2, 4'd3, 4'd0, 16'h5678, 16'h9ABC},
        '{1'b0, 2'd2, 24'h000108, 32'h0,         4'd3, 4'd0, 4'd2, 16'h1111, 16'h2222},
        '{1'b0, 2'd1, 24'h000202, 32'h0,         4'd1, 4'd0, 4'd0, 16'hBEEF, 16'h0000},
        '{1'b0, 2'd0, 24'h000301, 32'h0,         4'd0, 4'd0, 4'd0, 16'hC3A5, 16'h0000},
        '{1'b0, 2'd0, 24'h000300, 32'h0,         4'd2, 4'd1, 4'd0, 16'hC3A5, 16'h0000},
        '{1'b1, 2'd2, 24'h000400, 32'hDEADBEEF,  4'd0, 4'd1, 4'd1, 16'h0000, 16'h0000},
        '{1'b1, 2'd1, 24'h000502, 32'h00005A5A,  4'd2, 4'd4, 4'd0, 16'h0000, 16'h0000},
        '{1'b1, 2'd0, 24'h000601, 32'h00000077,  4'd1, 4'd0, 4'd0, 16'h0000, 16'h0000},
        '{1'b1, 2'd0, 24'h000600, 32'h000000E1,  4'd3, 4'd0, 4'd0, 16'h0000, 16'h0000},
        '{1'b0, 2'd3, 24'h000700, 32'h0,         4'd0, 4'd0, 4'd0, 16'h0F0F, 16'hF0F0}
    };

    int n_tests = 0;
    int n_fail  = 0;

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic int eff_ws(int cfg, bit wr, bit [1:0] sz);
        int m = (wr || sz[1]) ? 2 : 1;
        return (cfg < m) ? m : cfg;
    endfunction

    // strobe clocks: decision at count k uses the wait sample from edge k-1 of the strobe
    function automatic int exp_len(int ws, int lowc);
        int k = ws;
        while ((k - 1 >= 1) && (k - 1 <= lowc)) k++;
        return k + 1;
    endfunction

    task automatic run(input vec_t v, input bit hold);
        int          lowc [2];
        int          gaps = 0;
        int          h = 0;
        int          cyc = 0;
        int          e0, e1, lim;
        bit          word, got_done = 0;
        bit          bad_addr = 0, bad_dout = 0, bad_bsel = 0, bad_strb = 0, bad_rdy = 0;
        logic [AW-1:0] ea;
        logic [15:0] ed;
        logic [1:0]  eb;
        logic [31:0] er;
        lowc = '{0, 0};
        word = v.sz[1];
        e0 = exp_len(eff_ws(int'(v.ws), v.wr, v.sz), int'(v.l0));
        e1 = exp_len(eff_ws(int'(v.ws), v.wr, v.sz), int'(v.l1));
        eb = (v.sz == 2'd0) ? (v.ad[0] ? 2'b10 : 2'b01) : 2'b11;
        if (word)              er = {v.dhi, v.dlo};
        else if (v.sz == 2'd1) er = {16'h0, v.dlo};
        else                   er = {24'h0, (v.ad[0] ? v.dlo[15:8] : v.dlo[7:0])};

        @(negedge clk);
        req_write = v.wr; req_size = v.sz; req_addr = v.ad; req_wdata = v.wd;
        cfg_ws = v.ws; bus_din = v.dlo; ext_wait_n = 1'b1; req_valid = 1'b1;
        @(posedge clk); #1;
        if (hold) begin
            req_addr  = 24'hFFFFF0;
            req_wdata = 32'h0;
        end else begin
            req_valid = 1'b0;
        end

        while (!got_done && cyc < 200) begin
            cyc++;
            if (done) begin
                got_done   = 1;
                req_valid  = 1'b0;
                ext_wait_n = 1'b1;
                chk(req_ready == 1'b1, "R9 ready in done clock", 32'(req_ready), 32'd1);
                if (!v.wr) chk(rdata == er, "R6 read data", rdata, er);
            end else begin
                if (req_ready) bad_rdy = 1;
                if (!bus_rd_n || !bus_we_n) begin
                    ea = v.ad + ((h != 0) ? 24'd2 : 24'd0);
                    if (word)              ed = (h != 0) ? v.wd[31:16] : v.wd[15:0];
                    else if (v.sz == 2'd1) ed = v.wd[15:0];
                    else                   ed = {v.wd[7:0], v.wd[7:0]};
                    if (bus_cs_n) bad_strb = 1;
                    if (v.wr ? !bus_rd_n : !bus_we_n) bad_strb = 1;
                    if (bus_addr != ea) bad_addr = 1;
                    if (v.wr && bus_dout != ed) bad_dout = 1;
                    if (bus_bsel != eb) bad_bsel = 1;
                    lim = (h != 0) ? int'(v.l1) : int'(v.l0);
                    ext_wait_n = (lowc[h] < lim) ? 1'b0 : 1'b1;
                    lowc[h]++;
                end else begin
                    ext_wait_n = 1'b1;
                    if (!bus_cs_n) begin
                        gaps++;
                        h = 1;
                        bus_din = v.dhi;
                    end
                end
            end
            if (!got_done) begin
                @(posedge clk); #1;
            end
        end

        chk(got_done, "R9 done pulse seen", 32'(got_done), 32'd1);
        chk(lowc[0] == e0, (v.l0 == 0) ? "R3 first strobe length" : "R4 first strobe length (wait)",
            32'(lowc[0]), 32'(e0));
        if (word) begin
            chk(lowc[1] == e1, "R5 second strobe length", 32'(lowc[1]), 32'(e1));
            chk(gaps == 1, "R5 one gap clock", 32'(gaps), 32'd1);
        end else begin
            chk(gaps == 0, "R5 no gap for single cycle", 32'(gaps), 32'd0);
        end
        chk(!bad_addr, hold ? "R2 address unaffected while busy" : "R5 bus address", 32'(bad_addr), 32'd0);
        if (v.wr) chk(!bad_dout, "R7 write data lanes", 32'(bad_dout), 32'd0);
        chk(!bad_bsel, "R7 byte select", 32'(bad_bsel), 32'd0);
        chk(!bad_strb, "R8 strobe and select", 32'(bad_strb), 32'd0);
        chk(!bad_rdy, "R2 ready low while busy", 32'(bad_rdy), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired");
        n_tests++;
        n_fail++;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(bus_cs_n && bus_rd_n && bus_we_n, "R1 strobes high in reset",
            {29'h0, bus_cs_n, bus_rd_n, bus_we_n}, 32'h7);
        chk(!done && req_ready, "R1 done low, ready high in reset",
            {30'h0, done, req_ready}, 32'h1);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #1;
        chk(bus_cs_n && req_ready && !done, "R1 idle after reset",
            {29'h0, bus_cs_n, req_ready, done}, 32'h6);

        for (int i = 0; i < NV; i++) run(VEC[i], 1'b0);

        // request held high with changed fields throughout a word read
        run('{1'b0, 2'd2, 24'h000800, 32'h0, 4'd2, 4'd2, 4'd1, 16'h4321, 16'h8765}, 1'b1);
        @(posedge clk); #1;
        chk(!done, "R9 done lasts one clock", 32'(done), 32'd0);
        chk(bus_cs_n, "R2 no acceptance after valid dropped", 32'(bus_cs_n), 32'd1);

        // back-to-back write then read
        run('{1'b1, 2'd1, 24'h000900, 32'h0000CAFE, 4'd2, 4'd0, 4'd0, 16'h0, 16'h0}, 1'b0);
        run('{1'b0, 2'd1, 24'h000900, 32'h0,        4'd2, 4'd1, 4'd0, 16'hCAFE, 16'h0}, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule